// File: doc/BRIEF.md
# SIMD Lane-Mask Branch Sequencer

This block steers a group of ALU lanes that share one instruction decoder. Every lane gets the same instruction in the same clock, and each lane works on its own data item. A branch may split the lanes. When it does, the block runs the taken side first and then the other side, one after the other. A per-lane active mask decides which lanes commit a result on each side. Once the branch closes, the mask returns to what it was before the branch, so code outside the branch runs on every lane that was active there.

A small stack holds the enclosing mask for each open branch, so branches can nest. An instruction seen while no lane is active is not issued. It raises no write enable and does not count as an issue slot, so a side that no lane takes costs nothing. Two counters record how many ALU instructions were issued and how many lane-cycles did useful work. Their ratio is the lane utilisation. It falls to one in eight when a single lane is active.

Top module: `simd_branch_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset the mask is all ones, the nesting depth is 0, both counters are 0, every lane accumulator is 0 and no write enable is high.
- R2: Opcode 3'd1 (load) copies each active lane's own input slice into its accumulator. Opcode 3'd2 (multiply-add) sets each active lane's accumulator to acc*in_mul + in_add, truncated to DW bits. Every active lane updates on the same clock edge.
- R3: Opcode 3'd4 (branch open) pushes the current mask onto the stack, raises the depth by one, and sets the new mask to the old mask AND lane_cond. Bit i of a mask belongs to lane i.
- R4: Opcode 3'd5 (branch flip) sets the mask to the enclosing mask AND NOT the current mask. The lanes that took the first side are then switched off, and the remaining lanes of the enclosing mask are switched on.
- R5: Opcode 3'd6 (branch close) restores the enclosing mask from the stack and lowers the depth by one.
- R6: During a load or multiply-add, a lane whose mask bit is clear keeps lane_we low and keeps its accumulator unchanged. lane_we is combinational and is valid in the same cycle as the instruction.
- R7: A load or multiply-add that arrives while the mask is all zero is skipped. No write enable rises and neither counter changes. Branch opcodes still update the mask and the depth.
- R8: Each issued ALU instruction adds one to issue_cnt and adds the number of active lanes to active_cnt.
- R9: Branches nest up to DEPTH levels. A branch open at full depth is ignored. A branch flip or branch close at depth 0 is ignored. In both cases the mask and the depth stay as they were.
- R10: While in_valid is low, the block changes no state and raises no write enable. Opcode 3'd0 is a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is present this cycle |
| in_op | input | 3 | Opcode |
| lane_cond | input | LANES | Branch condition from each lane, bit i belongs to lane i |
| in_mul | input | DW | Multiplier for the multiply-add |
| in_add | input | DW | Addend for the multiply-add |
| lane_in | input | LANES*DW | Per-lane load data, lane i in bits i*DW and up |
| lane_we | output | LANES | Per-lane commit enable for this cycle |
| lane_acc | output | LANES*DW | Per-lane accumulator, packed the same way as lane_in |
| active_mask | output | LANES | Current active-lane mask |
| nest_depth | output | $clog2(DEPTH+1) | Number of open branches |
| active_cnt | output | CNT_W | Sum of active lanes over all issued instructions |
| issue_cnt | output | CNT_W | Number of issued ALU instructions |

## Verification
The bench builds the block with its default parameters: eight lanes, 8-bit data, a four-entry stack and 16-bit counters. With eight lanes, the three-true, five-false split and the single-lane worst case appear exactly as stated. With 8-bit data, the multiply-add wraps within a few operations, so truncation gets checked. With four stack entries, the bench reaches full depth and the ignored fifth branch open in a handful of instructions. It also runs a branch nested inside a side that no lane takes, to show that skipping follows the stack.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_MADD  = 3'd2,
        OP_IF    = 3'd4,
        OP_ELSE  = 3'd5,
        OP_ENDIF = 3'd6
    } op_e;

    function automatic logic op_is_alu(input op_e op);
        return (op == OP_LOAD) || (op == OP_MADD);
    endfunction

endpackage

// File: rtl/simd_mask_stack.sv
module simd_mask_stack
    import simd_seq_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DEPTH = 4,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  op_e              op,
    input  logic [LANES-1:0] cond,
    output logic [LANES-1:0] mask,
    output logic [SP_W-1:0]  depth
);
    localparam int SLOTS = 1 << SP_W;

    logic [LANES-1:0] stk [SLOTS];
    logic [SP_W-1:0]  sp;
    logic [SP_W-1:0]  sp_m1;
    logic [LANES-1:0] parent;
    logic             do_push;
    logic             do_flip;
    logic             do_pop;

    always_comb begin
        sp_m1   = sp - 1'b1;
        parent  = stk[sp_m1];
        do_push = valid && (op == OP_IF)    && (sp != SP_W'(DEPTH));
        do_flip = valid && (op == OP_ELSE)  && (sp != '0);
        do_pop  = valid && (op == OP_ENDIF) && (sp != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp   <= '0;
            mask <= '1;
            for (int i = 0; i < SLOTS; i++) stk[i] <= '0;
        end else if (do_push) begin
            stk[sp] <= mask;
            mask    <= mask & cond;
            sp      <= sp + 1'b1;
        end else if (do_flip) begin
            mask <= parent & ~mask;
        end else if (do_pop) begin
            mask <= parent;
            sp   <= sp_m1;
        end
    end

    assign depth = sp;

    // R3
    if_narrow_chk: assert property (@(posedge clk) disable iff (rst)
        do_push |=> ((mask & ~$past(mask)) == '0));

    // R4
    else_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        do_flip |=> ((mask & $past(mask)) == '0));

    // R5
    endif_depth_chk: assert property (@(posedge clk) disable iff (rst)
        do_pop |=> (sp < $past(sp)));

    // R9
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_W'(DEPTH));

endmodule

// File: rtl/simd_lane.sv
module simd_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          load,
    input  logic [DW-1:0] mul,
    input  logic [DW-1:0] add,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] acc
);
    logic [DW-1:0] nxt;

    always_comb nxt = load ? din : (acc * mul + add);

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (we) acc <= nxt;
    end

    // R6
    masked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(acc));

endmodule

// File: rtl/simd_util_counter.sv
module simd_util_counter #(
    parameter int LANES = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [LANES-1:0] lanes,
    output logic [CNT_W-1:0] active_cnt,
    output logic [CNT_W-1:0] issue_cnt
);
    localparam int PC_W = $clog2(LANES + 1);

    logic [PC_W-1:0] pc;

    always_comb begin
        pc = '0;
        for (int i = 0; i < LANES; i++) pc = pc + PC_W'(lanes[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_cnt <= '0;
            issue_cnt  <= '0;
        end else if (issue) begin
            active_cnt <= active_cnt + CNT_W'(pc);
            issue_cnt  <= issue_cnt + 1'b1;
        end
    end

    // R8
    active_grows_chk: assert property (@(posedge clk) disable iff (rst)
        issue |=> (active_cnt != $past(active_cnt)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> ($stable(active_cnt) && $stable(issue_cnt)));

endmodule

// File: rtl/simd_branch_seq.sv
module simd_branch_seq
    import simd_seq_pkg::*;
#(
    parameter int LANES = 8,
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    localparam int SP_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2:0]          in_op,
    input  logic [LANES-1:0]    lane_cond,
    input  logic [DW-1:0]       in_mul,
    input  logic [DW-1:0]       in_add,
    input  logic [LANES*DW-1:0] lane_in,
    output logic [LANES-1:0]    lane_we,
    output logic [LANES*DW-1:0] lane_acc,
    output logic [LANES-1:0]    active_mask,
    output logic [SP_W-1:0]     nest_depth,
    output logic [CNT_W-1:0]    active_cnt,
    output logic [CNT_W-1:0]    issue_cnt
);
    op_e  op;
    logic issue;
    logic is_load;

    always_comb begin
        op      = op_e'(in_op);
        issue   = in_valid && op_is_alu(op) && (active_mask != '0);
        is_load = (op == OP_LOAD);
        lane_we = issue ? active_mask : '0;
    end

    simd_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .op    (op),
        .cond  (lane_cond),
        .mask  (active_mask),
        .depth (nest_depth)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        simd_lane #(.DW(DW)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .we   (lane_we[g]),
            .load (is_load),
            .mul  (in_mul),
            .add  (in_add),
            .din  (lane_in[g*DW +: DW]),
            .acc  (lane_acc[g*DW +: DW])
        );
    end

    simd_util_counter #(.LANES(LANES), .CNT_W(CNT_W)) u_util (
        .clk        (clk),
        .rst        (rst),
        .issue      (issue),
        .lanes      (lane_we),
        .active_cnt (active_cnt),
        .issue_cnt  (issue_cnt)
    );

    // R7
    zero_mask_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (active_mask == '0) |=> $stable(issue_cnt));

    // R10
    invalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(active_mask) && $stable(nest_depth) && $stable(lane_acc)));

endmodule

// File: tb/sim_simd_branch_seq.sv
module sim_simd_branch_seq;
    import simd_seq_pkg::*;

    localparam int LANES = 8;
    localparam int DW    = 8;

    typedef struct packed {
        op_e        op;
        logic [7:0] cond;
        logic [7:0] mul;
        logic [7:0] add;
        logic [7:0] we;
        logic [7:0] mask;
        logic [2:0] depth;
    } vec_t;

    localparam vec_t TBL [20] = '{
        '{OP_LOAD,  8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 3'd0},
        '{OP_IF,    8'h07, 8'h00, 8'h00, 8'h00, 8'h07, 3'd1},
        '{OP_MADD,  8'h00, 8'h02, 8'h01, 8'h07, 8'h07, 3'd1},
        '{OP_ELSE,  8'h00, 8'h00, 8'h00, 8'h00, 8'hF8, 3'd1},
        '{OP_MADD,  8'h00, 8'h01, 8'h05, 8'hF8, 8'hF8, 3'd1},
        '{OP_IF,    8'h10, 8'h00, 8'h00, 8'h00, 8'h10, 3'd2},
        '{OP_MADD,  8'h00, 8'h03, 8'h00, 8'h10, 8'h10, 3'd2},
        '{OP_ELSE,  8'h00, 8'h00, 8'h00, 8'h00, 8'hE8, 3'd2},
        '{OP_MADD,  8'h00, 8'h11, 8'h01, 8'hE8, 8'hE8, 3'd2},
        '{OP_ENDIF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF8, 3'd1},
        '{OP_ENDIF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd0},
        '{OP_IF,    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd1},
        '{OP_MADD,  8'h00, 8'h05, 8'h05, 8'h00, 8'h00, 3'd1},
        '{OP_IF,    8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 3'd2},
        '{OP_LOAD,  8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd2},
        '{OP_ENDIF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 3'd1},
        '{OP_ELSE,  8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd1},
        '{OP_MADD,  8'h00, 8'hFF, 8'h02, 8'hFF, 8'hFF, 3'd1},
        '{OP_ENDIF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd0},
        '{OP_NOP,   8'hFF, 8'h07, 8'h07, 8'h00, 8'hFF, 3'd0}
    };

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [2:0]          in_op = 3'd0;
    logic [LANES-1:0]    lane_cond = '0;
    logic [DW-1:0]       in_mul = '0;
    logic [DW-1:0]       in_add = '0;
    logic [LANES*DW-1:0] lane_in;
    logic [LANES-1:0]    lane_we;
    logic [LANES*DW-1:0] lane_acc;
    logic [LANES-1:0]    active_mask;
    logic [2:0]          nest_depth;
    logic [15:0]         active_cnt;
    logic [15:0]         issue_cnt;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [DW-1:0] acc_m [LANES];
    int            iss_m = 0;
    int            act_m = 0;

    always #5 clk = ~clk;

    simd_branch_seq u0 (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_op       (in_op),
        .lane_cond   (lane_cond),
        .in_mul      (in_mul),
        .in_add      (in_add),
        .lane_in     (lane_in),
        .lane_we     (lane_we),
        .lane_acc    (lane_acc),
        .active_mask (active_mask),
        .nest_depth  (nest_depth),
        .active_cnt  (active_cnt),
        .issue_cnt   (issue_cnt)
    );

    always_comb begin
        for (int i = 0; i < LANES; i++) lane_in[i*DW +: DW] = DW'(8'h10 + i);
    end

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [63:0] model_acc();
        logic [63:0] v = '0;
        for (int i = 0; i < LANES; i++) v[i*8 +: 8] = acc_m[i];
        return v;
    endfunction

    task automatic step(input logic v, input op_e op, input logic [7:0] cond,
                        input logic [7:0] mul, input logic [7:0] add,
                        input logic [7:0] exp_we, input logic [7:0] exp_mask,
                        input logic [2:0] exp_depth, input string req);
        @(negedge clk);
        in_valid  = v;
        in_op     = op;
        lane_cond = cond;
        in_mul    = mul;
        in_add    = add;
        #1;
        chk(req, "lane_we", 64'(lane_we), 64'(exp_we));
        @(posedge clk);
        #1;
        for (int i = 0; i < LANES; i++) begin
            if (exp_we[i]) begin
                if (op == OP_LOAD) acc_m[i] = 8'(8'h10 + i);
                else               acc_m[i] = 8'(acc_m[i] * mul + add);
            end
        end
        if (exp_we != '0) begin
            iss_m++;
            act_m += $countones(exp_we);
        end
        chk(req, "active_mask", 64'(active_mask), 64'(exp_mask));
        chk(req, "nest_depth", 64'(nest_depth), 64'(exp_depth));
        chk("R6", "lane_acc", 64'(lane_acc), model_acc());
        chk("R8", "issue_cnt", 64'(issue_cnt), 64'(iss_m));
        chk("R8", "active_cnt", 64'(active_cnt), 64'(act_m));
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_reset();
        chk("R1", "active_mask", 64'(active_mask), 64'hFF);
        chk("R1", "nest_depth", 64'(nest_depth), 64'd0);
        chk("R1", "issue_cnt", 64'(issue_cnt), 64'd0);
        chk("R1", "active_cnt", 64'(active_cnt), 64'd0);
        chk("R1", "lane_acc", 64'(lane_acc), 64'd0);
        chk("R1", "lane_we", 64'(lane_we), 64'd0);
    endtask

    function automatic string tag_of(input op_e op, input logic [7:0] we);
        case (op)
            OP_IF:    return "R3";
            OP_ELSE:  return "R4";
            OP_ENDIF: return "R5";
            OP_NOP:   return "R10";
            default:  return (we == '0) ? "R7" : "R2";
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < LANES; i++) acc_m[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check_reset();
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < 20; k++) begin
            step(1'b1, TBL[k].op, TBL[k].cond, TBL[k].mul, TBL[k].add,
                 TBL[k].we, TBL[k].mask, TBL[k].depth, tag_of(TBL[k].op, TBL[k].we));
        end

        // R9: fill the stack, then an extra open is ignored
        for (int d = 1; d <= 4; d++)
            step(1'b1, OP_IF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 3'(d), "R9");
        step(1'b1, OP_IF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd4, "R9");
        for (int d = 3; d >= 0; d--)
            step(1'b1, OP_ENDIF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'(d), "R9");
        // R9: close and flip at depth 0 are ignored
        step(1'b1, OP_ENDIF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd0, "R9");
        step(1'b1, OP_ELSE,  8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd0, "R9");

        // R10: invalid instruction changes nothing
        step(1'b0, OP_MADD, 8'h00, 8'h03, 8'h09, 8'h00, 8'hFF, 3'd0, "R10");
        step(1'b0, OP_IF,   8'h01, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd0, "R10");

        // R8: worst case, one lane of eight active
        step(1'b1, OP_IF,    8'h80, 8'h00, 8'h00, 8'h00, 8'h80, 3'd1, "R3");
        step(1'b1, OP_MADD,  8'h00, 8'h01, 8'h01, 8'h80, 8'h80, 3'd1, "R8");
        step(1'b1, OP_LOAD,  8'h00, 8'h00, 8'h00, 8'h80, 8'h80, 3'd1, "R2");
        step(1'b1, OP_ENDIF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 3'd0, "R5");

        // R1: reset in the middle of a branch
        step(1'b1, OP_IF, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h0F, 3'd1, "R3");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_reset();
        @(negedge clk);
        rst = 1'b0;

        finish_run();
    end

endmodule